// File: doc/BRIEF.md
# Host Byte FIFO with Command Capture

This block is the byte port a host processor uses to move programmed-I/O data through a SCSI host adapter. A single byte-wide host access path serves two buffers. In data mode, writes go into a shallow data FIFO. In command-collection mode, writes go into a separate command buffer. A downstream command engine reads that buffer by index. Host reads pop the data FIFO only when the bus phase bits show a data-in style phase. When the phase bits are all zero, a read returns zero and leaves the FIFO untouched.

The block keeps a signed remaining-byte count and a fill count. The fill count is the number of unread bytes in the data FIFO. A selection start clears the FIFO pointers and the remaining count. A status-response load replaces the FIFO contents with a two-byte reply: the status byte, then a zero byte. The read and write pointers return to zero whenever a read leaves them equal. The data FIFO refuses a write one entry before its storage is physically full. Bus signalling and command decoding are done elsewhere.

Top module: `hbf_byte_port`

## Requirements
- R1: After synchronous reset, host_rdata, fill_count, remain, overrun, cmd_active and cmd_count are all zero.
- R2: In data mode, a host write with fewer than DEPTH-1 bytes stored appends the byte. In the following cycle, fill_count and remain are each one higher.
- R3: In data mode, a host write while the write pointer sits at DEPTH-1 is dropped. overrun is high for exactly the following cycle, and fill_count and remain do not change. This holds even when earlier entries have already been read out, so at most DEPTH-1 bytes can be written between two pointer resets.
- R4: A host read with phase_bits nonzero and fill_count nonzero returns the oldest unread byte on host_rdata in the next cycle. It lowers fill_count and remain by one. Bytes come out in the order they were written.
- R5: A host read with phase_bits nonzero and an empty FIFO leaves host_rdata, fill_count and remain unchanged.
- R6: A host read with phase_bits equal to 3'b000 drives host_rdata to 0x00 and removes nothing. fill_count and remain are unchanged.
- R7: When a read empties the FIFO, both pointers go back to zero. After that, DEPTH-1 further bytes can be written without overrun.
- R8: In command mode (cmd_active high), a host write stores the byte at command index cmd_count and increments cmd_count. The data FIFO's fill_count and remain are unchanged. cmd_byte returns the byte stored at index cmd_idx.
- R9: In command mode with cmd_count equal to CMD_DEPTH, a host write is dropped. overrun is high in the next cycle and cmd_count stays at CMD_DEPTH.
- R10: resp_load discards the FIFO contents. It leaves fill_count = 2 and remain = 2. The next two reads return resp_status and then 0x00.
- R11: sel_begin sets fill_count and remain to zero in the next cycle. A later read then returns nothing new.
- R12: cmd_enter raises cmd_active and clears cmd_count. cmd_leave lowers cmd_active and clears cmd_count. If both arrive in the same cycle, cmd_enter takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the FIFO address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe for the FIFO address |
| host_rdata | output | 8 | Byte returned by the latest read |
| phase_bits | input | 3 | Bus phase bits from the status register; 3'b000 means data out |
| sel_begin | input | 1 | Selection start: clear pointers and remaining count |
| resp_load | input | 1 | Load the two-byte status response |
| resp_status | input | 8 | Status byte used by resp_load |
| cmd_enter | input | 1 | Enter command-collection mode |
| cmd_leave | input | 1 | Leave command-collection mode |
| cmd_idx | input | CIDX_W (4) | Command buffer read index |
| cmd_byte | output | 8 | Command byte at cmd_idx |
| fill_count | output | PTR_W+1 (5) | Unread bytes in the data FIFO |
| remain | output | CNT_W (8) | Signed remaining-byte count |
| cmd_active | output | 1 | Command-collection mode is active |
| cmd_count | output | CL_W (5) | Command bytes collected |
| overrun | output | 1 | One-cycle flag for a dropped write |

## Verification
A write pointer that fails to snap back stays hidden while the FIFO is draining. It shows up as a false overrun pulse: a burst that refills an emptied FIFO reports overrun after fewer than DEPTH-1 bytes. A stuck read pointer shows up on host_rdata at the next pop as a repeated or skipped byte. A mis-steered write in command mode shows up at once on fill_count, or later as a wrong cmd_byte. A lost status-load shows up on the next two reads. All of these faults reach the ports within one access of the stimulus that exposes them.

// File: rtl/hbf_pkg.sv
// Package: shared byte type and the access classes decoded by the controller.
// Assumes a byte-wide host port.
package hbf_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_DATA_WR,
        ACC_CMD_WR,
        ACC_DROP,
        ACC_POP,
        ACC_ZERO_RD,
        ACC_EMPTY_RD
    } acc_kind_e;
endpackage

// File: rtl/hbf_byte_ram.sv
// Module: small byte storage with one indexed write port and one
// asynchronous read port. When PAIR_LOAD is set, it also has a pair-load
// port that writes entries 0 and 1 in one cycle. Assumes DEPTH >= 2.
// Contents are cleared by reset.
module hbf_byte_ram #(
    parameter int DEPTH     = 16,
    parameter bit PAIR_LOAD = 1'b0,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  hbf_pkg::byte_t wdata,
    input  logic          pair_we,
    input  hbf_pkg::byte_t pair_b0,
    input  logic [AW-1:0] raddr,
    output hbf_pkg::byte_t rdata
);
    hbf_pkg::byte_t mem [DEPTH];

    // Storage update: reset clear, pair load first, otherwise single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (PAIR_LOAD && pair_we) begin
            mem[0] <= pair_b0;
            mem[1] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read path: combinational lookup.
    assign rdata = mem[raddr];
endmodule

// File: rtl/hbf_ctrl.sv
// Module: pointer, count and mode controller for the byte port.
// Classifies each host access and updates the data pointers, the signed
// remaining count and the command-collection state. Assumes host_wr and
// host_rd are never high together. sel_begin takes priority over
// resp_load, and both take priority over data-FIFO accesses in the same
// cycle. Command-buffer writes are unaffected by either.
module hbf_ctrl #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    parameter int CNT_W     = 8,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CL_W     = $clog2(CMD_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [2:0]              phase_bits,
    input  logic                    sel_begin,
    input  logic                    resp_load,
    input  logic                    cmd_enter,
    input  logic                    cmd_leave,
    output logic [PTR_W-1:0]        rptr,
    output logic [PTR_W-1:0]        wptr,
    output logic signed [CNT_W-1:0] remain,
    output logic                    cmd_active,
    output logic [CL_W-1:0]         cmd_count,
    output logic                    overrun,
    output logic                    data_we,
    output logic                    cmd_we,
    output logic                    pop,
    output logic                    zero_rd
);
    import hbf_pkg::*;

    localparam logic [PTR_W-1:0] WLIMIT = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] RESP_W = PTR_W'(2);
    localparam logic [CL_W-1:0]  CFULL  = CL_W'(CMD_DEPTH);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic signed [CNT_W-1:0] TWO = CNT_W'(2);

    acc_kind_e        kind;
    logic             fifo_busy;
    logic [PTR_W-1:0] rptr_n, wptr_n;

    // Data-FIFO accesses yield to selection start and response load.
    assign fifo_busy = sel_begin || resp_load;

    // Access classification for the current cycle.
    always_comb begin
        kind = ACC_IDLE;
        if (host_wr) begin
            if (cmd_active)
                kind = (cmd_count == CFULL) ? ACC_DROP : ACC_CMD_WR;
            else if (!fifo_busy)
                kind = (wptr == WLIMIT) ? ACC_DROP : ACC_DATA_WR;
        end else if (host_rd && !fifo_busy) begin
            if (phase_bits == 3'b000)  kind = ACC_ZERO_RD;
            else if (rptr < wptr)      kind = ACC_POP;
            else                       kind = ACC_EMPTY_RD;
        end
    end

    assign data_we = (kind == ACC_DATA_WR);
    assign cmd_we  = (kind == ACC_CMD_WR);
    assign pop     = (kind == ACC_POP);
    assign zero_rd = (kind == ACC_ZERO_RD);

    // Next pointers before the snap-to-zero rule.
    assign rptr_n = rptr + PTR_W'(pop);
    assign wptr_n = wptr + PTR_W'(data_we);

    // Data pointers and signed remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_begin) begin
            rptr   <= '0;
            wptr   <= '0;
            remain <= '0;
        end else if (resp_load) begin
            rptr   <= '0;
            wptr   <= RESP_W;
            remain <= TWO;
        end else begin
            if (rptr_n == wptr_n) begin
                rptr <= '0;
                wptr <= '0;
            end else begin
                rptr <= rptr_n;
                wptr <= wptr_n;
            end
            if (data_we)  remain <= remain + ONE;
            else if (pop) remain <= remain - ONE;
        end
    end

    // Command-collection mode and its byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_active <= 1'b0;
            cmd_count  <= '0;
        end else if (cmd_enter) begin
            cmd_active <= 1'b1;
            cmd_count  <= '0;
        end else if (cmd_leave) begin
            cmd_active <= 1'b0;
            cmd_count  <= '0;
        end else if (cmd_we) begin
            cmd_count  <= cmd_count + CL_W'(1);
        end
    end

    // One-cycle overrun flag for a dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= (kind == ACC_DROP);
    end
endmodule

// File: rtl/hbf_byte_port.sv
// Module: host byte FIFO with command capture (top level).
// Steers host writes to the data FIFO or the command buffer and returns
// popped bytes on host_rdata. Exposes the fill count, the remaining count
// and the command byte count. Assumes a single byte port, so a read and a
// write never occur in the same cycle.
module hbf_byte_port #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    parameter int CNT_W     = 8,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CIDX_W   = $clog2(CMD_DEPTH),
    localparam int CL_W     = $clog2(CMD_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic [7:0]              host_wdata,
    input  logic                    host_rd,
    output logic [7:0]              host_rdata,
    input  logic [2:0]              phase_bits,
    input  logic                    sel_begin,
    input  logic                    resp_load,
    input  logic [7:0]              resp_status,
    input  logic                    cmd_enter,
    input  logic                    cmd_leave,
    input  logic [CIDX_W-1:0]       cmd_idx,
    output logic [7:0]              cmd_byte,
    output logic [PTR_W:0]          fill_count,
    output logic signed [CNT_W-1:0] remain,
    output logic                    cmd_active,
    output logic [CL_W-1:0]         cmd_count,
    output logic                    overrun
);
    logic [PTR_W-1:0] rptr, wptr;
    logic             data_we, cmd_we, pop, zero_rd;
    logic [7:0]       fifo_q;

    hbf_ctrl #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .phase_bits (phase_bits),
        .sel_begin  (sel_begin),
        .resp_load  (resp_load),
        .cmd_enter  (cmd_enter),
        .cmd_leave  (cmd_leave),
        .rptr       (rptr),
        .wptr       (wptr),
        .remain     (remain),
        .cmd_active (cmd_active),
        .cmd_count  (cmd_count),
        .overrun    (overrun),
        .data_we    (data_we),
        .cmd_we     (cmd_we),
        .pop        (pop),
        .zero_rd    (zero_rd)
    );

    hbf_byte_ram #(.DEPTH(DEPTH), .PAIR_LOAD(1'b1)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (data_we),
        .waddr   (wptr),
        .wdata   (host_wdata),
        .pair_we (resp_load && !sel_begin),
        .pair_b0 (resp_status),
        .raddr   (rptr),
        .rdata   (fifo_q)
    );

    hbf_byte_ram #(.DEPTH(CMD_DEPTH), .PAIR_LOAD(1'b0)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cmd_we),
        .waddr   (cmd_count[CIDX_W-1:0]),
        .wdata   (host_wdata),
        .pair_we (1'b0),
        .pair_b0 (8'h00),
        .raddr   (cmd_idx),
        .rdata   (cmd_byte)
    );

    // Host read register: popped byte, zero on a data-out read, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (pop)     host_rdata <= fifo_q;
        else if (zero_rd) host_rdata <= '0;
    end

    // Unread bytes between the two pointers.
    assign fill_count = {1'b0, wptr} - {1'b0, rptr};
endmodule

// File: rtl/hbf_checker.sv
// Module: property checker for hbf_byte_port, attached by bind.
// Assumes the same parameters as the instance it watches.
module hbf_checker #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    parameter int CNT_W     = 8,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CL_W     = $clog2(CMD_DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    host_wr,
    input logic                    host_rd,
    input logic [2:0]              phase_bits,
    input logic                    sel_begin,
    input logic                    resp_load,
    input logic                    cmd_enter,
    input logic                    cmd_leave,
    input logic [7:0]              host_rdata,
    input logic [PTR_W:0]          fill_count,
    input logic signed [CNT_W-1:0] remain,
    input logic                    cmd_active,
    input logic [CL_W-1:0]         cmd_count,
    input logic                    overrun,
    input logic [PTR_W-1:0]        rptr,
    input logic [PTR_W-1:0]        wptr
);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);
    logic quiet;
    assign quiet = !sel_begin && !resp_load;

    // R7: equal pointers only ever rest at zero.
    assert_ptr_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr == wptr) |-> (wptr == '0));

    // R2: an accepted data write raises remain by one.
    assert_wr_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !cmd_active && quiet && wptr != PTR_W'(DEPTH - 1))
        |=> (remain == $past(remain) + ONE));

    // R3: a write at the early-full point is dropped and flagged.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !cmd_active && quiet && wptr == PTR_W'(DEPTH - 1))
        |=> (overrun && $stable(fill_count) && $stable(remain)));

    // R6: a data-out read returns zero and pops nothing.
    assert_zero_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && phase_bits == 3'b000 && quiet)
        |=> (host_rdata == 8'h00 && $stable(fill_count)));

    // R9: a full command buffer drops the write.
    assert_cmd_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && cmd_active && cmd_count == CL_W'(CMD_DEPTH) && !cmd_enter && !cmd_leave)
        |=> (overrun && cmd_count == CL_W'(CMD_DEPTH)));

    // R11: selection start clears the counts.
    assert_sel_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_begin |=> (fill_count == '0 && remain == '0));

    // R8: the command count never passes the buffer size.
    assert_cmd_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_count <= CL_W'(CMD_DEPTH));

    // R12: leaving command mode clears the count.
    assert_cmd_leave_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_leave && !cmd_enter) |=> (!cmd_active && cmd_count == '0));
endmodule

bind hbf_byte_port hbf_checker #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .phase_bits (phase_bits),
    .sel_begin  (sel_begin),
    .resp_load  (resp_load),
    .cmd_enter  (cmd_enter),
    .cmd_leave  (cmd_leave),
    .host_rdata (host_rdata),
    .fill_count (fill_count),
    .remain     (remain),
    .cmd_active (cmd_active),
    .cmd_count  (cmd_count),
    .overrun    (overrun),
    .rptr       (rptr),
    .wptr       (wptr)
);

// File: tb/sim_hbf_byte_port.sv
// Scoreboard bench: driver tasks push expected values, monitor compares.
module sim_hbf_byte_port;
    localparam int DEPTH = 16;
    localparam int CMD_DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic [2:0] phase_bits = '0;
    logic       sel_begin = 1'b0, resp_load = 1'b0;
    logic [7:0] resp_status = '0;
    logic       cmd_enter = 1'b0, cmd_leave = 1'b0;
    logic [3:0] cmd_idx = '0;
    logic [7:0] cmd_byte;
    logic [4:0] fill_count;
    logic signed [7:0] remain;
    logic       cmd_active, overrun;
    logic [4:0] cmd_count;

    hbf_byte_port u0 (.*);

    always #4 clk = ~clk;   // 125 MHz

    typedef enum int {F_RD, F_FILL, F_REM, F_OVR, F_CMODE, F_CCNT, F_CBYTE} fld_e;
    typedef struct { fld_e f; int idx; int val; string req; } exp_t;
    exp_t exp_q[$];
    int  n_chk = 0, n_fail = 0;
    bit  mon_busy = 0, done = 0;

    // Model state derived from the requirements.
    int  m_mem[DEPTH];
    int  m_cmd[CMD_DEPTH];
    int  m_r = 0, m_w = 0, m_rem = 0, m_rd = 0, m_ovr = 0, m_cmode = 0, m_ccnt = 0;

    // Monitor: pops expected items and compares them with the outputs.
    initial forever begin
        exp_t e;
        int   act;
        wait (exp_q.size() != 0);
        mon_busy = 1;
        e = exp_q.pop_front();
        if (e.f == F_CBYTE) begin cmd_idx = 4'(e.idx); #1; end
        case (e.f)
            F_RD:    act = int'(host_rdata);
            F_FILL:  act = int'(fill_count);
            F_REM:   act = int'(remain);
            F_OVR:   act = int'(overrun);
            F_CMODE: act = int'(cmd_active);
            F_CCNT:  act = int'(cmd_count);
            default: act = int'(cmd_byte);
        endcase
        n_chk++;
        if (act != e.val) begin
            n_fail++;
            $display("FAIL %s field %s: actual %0d expected %0d", e.req, e.f.name(), act, e.val);
        end
        mon_busy = 0;
    end

    task automatic push(fld_e f, int v, string req, int idx = 0);
        exp_t e;
        e.f = f; e.val = v; e.req = req; e.idx = idx;
        exp_q.push_back(e);
    endtask

    task automatic settle();
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    // Ends one access: clears strobes after the edge and pushes the full expected view.
    task automatic finish_op(string req);
        @(negedge clk);
        host_wr = 0; host_rd = 0; sel_begin = 0; resp_load = 0; cmd_enter = 0; cmd_leave = 0;
        push(F_RD, m_rd, req);
        push(F_FILL, m_w - m_r, req);
        push(F_REM, m_rem, req);
        push(F_OVR, m_ovr, req);
        push(F_CMODE, m_cmode, req);
        push(F_CCNT, m_ccnt, req);
        settle();
    endtask

    task automatic do_write(int b, string req);
        host_wr = 1; host_wdata = 8'(b);
        m_ovr = 0;
        if (m_cmode != 0) begin
            if (m_ccnt == CMD_DEPTH) m_ovr = 1;
            else begin m_cmd[m_ccnt] = b; m_ccnt++; end
        end else if (m_w == DEPTH - 1) m_ovr = 1;
        else begin m_mem[m_w] = b; m_w++; m_rem++; end
        finish_op(req);
    endtask

    task automatic do_read(int ph, string req);
        host_rd = 1; phase_bits = 3'(ph);
        m_ovr = 0;
        if (ph == 0) m_rd = 0;
        else if (m_r < m_w) begin m_rd = m_mem[m_r]; m_r++; m_rem--; end
        if (m_r == m_w) begin m_r = 0; m_w = 0; end
        finish_op(req);
    endtask

    task automatic do_sel(string req);
        sel_begin = 1; m_ovr = 0; m_r = 0; m_w = 0; m_rem = 0;
        finish_op(req);
    endtask

    task automatic do_resp(int b, string req);
        resp_load = 1; resp_status = 8'(b); m_ovr = 0;
        m_mem[0] = b; m_mem[1] = 0; m_r = 0; m_w = 2; m_rem = 2;
        finish_op(req);
    endtask

    task automatic do_cmd(bit enter, string req);
        if (enter) begin cmd_enter = 1; m_cmode = 1; end
        else begin cmd_leave = 1; m_cmode = 0; end
        m_ccnt = 0; m_ovr = 0;
        finish_op(req);
    endtask

    // Driver: reset, then the access patterns for each requirement.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        push(F_RD, 0, "R1"); push(F_FILL, 0, "R1"); push(F_REM, 0, "R1");
        push(F_OVR, 0, "R1"); push(F_CMODE, 0, "R1"); push(F_CCNT, 0, "R1");
        settle();

        do_write(8'hA1, "R2"); do_write(8'hB2, "R2"); do_write(8'hC3, "R2");
        do_read(0, "R6");                                    // data-out read
        do_read(1, "R4"); do_read(3, "R4"); do_read(1, "R4"); // FIFO order
        do_read(1, "R5");                                    // empty read holds

        for (int i = 0; i < DEPTH - 1; i++) do_write(8'h10 + i, "R2");
        do_write(8'hEE, "R3");                               // early-full drop
        do_read(1, "R4");
        do_write(8'hEF, "R3");                               // still at limit
        for (int i = 0; i < DEPTH - 2; i++) do_read(2, "R7");
        for (int i = 0; i < DEPTH - 1; i++) do_write(8'h40 + i, "R7");
        do_read(1, "R4");

        do_sel("R11");
        do_read(1, "R11");

        do_write(8'h77, "R2");
        do_resp(8'h5A, "R10");
        do_read(1, "R10"); do_read(1, "R10");
        do_read(1, "R5");

        do_cmd(1, "R12");
        for (int i = 0; i < CMD_DEPTH; i++) do_write(8'h80 + 3 * i, "R8");
        do_write(8'hFF, "R9");
        push(F_CBYTE, m_cmd[0], "R8", 0);
        push(F_CBYTE, m_cmd[5], "R8", 5);
        push(F_CBYTE, m_cmd[15], "R8", 15);
        settle();
        do_cmd(0, "R12");
        do_write(8'h31, "R2");
        do_cmd(1, "R12");
        do_write(8'h32, "R8");
        do_cmd(1, "R12");                                    // re-enter clears count

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule